// File: doc/BRIEF.md
# Overlay Block Access Controller

This block sits between the command decoder and the array of a flash-style memory that has 32 equal main blocks and one overlay block. The overlay uses the same address range as main block 0, so every access in that range must be steered either to the main block or to the overlay. The block also decides whether program and erase requests may go ahead. It bases that decision on a digital input that reports whether the programming supply is present.

A one-cycle command selects the read source (array or identification codes), flips the overlay-visibility flag, or clears a sticky refusal error. Array accesses arrive as an operation code plus an address. For each access the block returns the decoded block index, an overlay select, a grant, a refusal and the read data. In identification mode the read data carries fixed codes instead of array contents.

Top module: `ovl_access_ctrl`

## Requirements
- R1: `blk_idx` equals the top five address bits (`acc_addr[17:13]`), so each block spans 8192 double-word addresses.
- R2: `sel_overlay` is 1 only for a read (`acc_op`=1) in block 0, in array mode, with `ovl_en`=1 and `vpp_ok`=1. In every other case it is 0 and the access goes to main block 0.
- R3: Program (`acc_op`=2) and erase (`acc_op`=3) are granted when `vpp_ok`=1. When `vpp_ok`=0 they are refused (`refused`=1, `grant`=0).
- R4: Reads are always granted and never refused. With `acc_op`=0 both `grant` and `refused` are 0.
- R5: Command 3 (toggle) inverts `ovl_en` on the next clock edge. Reset clears `ovl_en` to 0.
- R6: A refused request sets `err_flag` on the next edge. The flag stays set until command 4 (clear). If a refusal and a clear fall in the same cycle, the flag ends up set.
- R7: Command 2 enters identification mode. There `rd_data` is 0x20 at address 0, 0xF0 at address 1, `VER_CODE` (3 bits) at address 2, and 0 at any other address, all zero-extended.
- R8: Command 1 returns to array mode, where `rd_data` equals `array_rdata`. Reset selects array mode and clears `err_flag`. Command 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / power-down |
| vpp_ok | input | 1 | Programming supply present |
| cmd | input | 3 | Command code, valid for one cycle (0 none, 1 array, 2 ident, 3 toggle, 4 clear) |
| acc_op | input | 2 | Access kind: 0 none, 1 read, 2 program, 3 erase |
| acc_addr | input | 18 | Double-word address |
| array_rdata | input | 32 | Data from the selected array block |
| blk_idx | output | 5 | Decoded main block index |
| sel_overlay | output | 1 | Access directed to overlay |
| grant | output | 1 | Access allowed |
| refused | output | 1 | Program/erase refused |
| rd_data | output | 32 | Read data returned to the host |
| err_flag | output | 1 | Sticky refusal error |
| ovl_en | output | 1 | Overlay read enable flag |
| sig_mode | output | 1 | Identification mode active |

## Verification
The bench keeps the default geometry of 18 address bits, 32 blocks and 32-bit data. This places block 0 at 0x00000–0x01FFF, so the edges at 0x01FFF and 0x02000 can be tried directly. It overrides `VER_CODE` with 6. A nonzero version therefore shows up at address 2 and cannot be confused with the zero returned for unused identification addresses.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_ARRAY  = 3'd1,
    CMD_IDENT  = 3'd2,
    CMD_TOGGLE = 3'd3,
    CMD_CLEAR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } op_e;

  function automatic logic is_modify(input logic [1:0] op);
    return (op == OP_PROG) || (op == OP_ERASE);
  endfunction

  function automatic logic [7:0] ident_code(input logic [1:0] loc,
                                            input logic [7:0] mfr,
                                            input logic [7:0] dev,
                                            input logic [2:0] ver);
    case (loc)
      2'd0:    return mfr;
      2'd1:    return dev;
      2'd2:    return {5'd0, ver};
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/ovl_mode_regs.sv
module ovl_mode_regs
  import ovl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd,
  output logic       ovl_en,
  output logic       sig_mode
);
  logic do_toggle, do_ident, do_array;
  assign do_toggle = (cmd == CMD_TOGGLE);
  assign do_ident  = (cmd == CMD_IDENT);
  assign do_array  = (cmd == CMD_ARRAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_en   <= 1'b0;
      sig_mode <= 1'b0;
    end else begin
      if (do_toggle) ovl_en <= ~ovl_en;
      if (do_ident) sig_mode <= 1'b1;
      else if (do_array) sig_mode <= 1'b0;
    end
  end

  a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    do_toggle |=> (ovl_en != $past(ovl_en)));
  a_r7_ident_enter: assert property (@(posedge clk) disable iff (!rst_n)
    do_ident |=> sig_mode);
  a_r8_array_enter: assert property (@(posedge clk) disable iff (!rst_n)
    do_array |=> !sig_mode);
endmodule

// File: rtl/ovl_gate.sv
module ovl_gate
  import ovl_pkg::*;
#(
  parameter int BLK_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       acc_op,
  input  logic [BLK_W-1:0] blk,
  input  logic             vpp_ok,
  input  logic             ovl_en,
  input  logic             sig_mode,
  output logic             sel_overlay,
  output logic             grant,
  output logic             refused
);
  logic in_blk0, is_rd, is_mod;
  assign in_blk0 = (blk == '0);
  assign is_rd   = (acc_op == OP_READ);
  assign is_mod  = is_modify(acc_op);

  always_comb begin
    sel_overlay = is_rd && in_blk0 && !sig_mode && ovl_en && vpp_ok;
    grant       = is_rd || (is_mod && vpp_ok);
    refused     = is_mod && !vpp_ok;
  end

  a_r3_no_modify_without_supply: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mod && !vpp_ok) |-> (!grant && refused));
  a_r2_overlay_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    sel_overlay |-> (in_blk0 && vpp_ok && ovl_en && !sig_mode));
  a_r4_read_never_refused: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> (grant && !refused));
endmodule

// File: rtl/ovl_err_track.sv
module ovl_err_track
  import ovl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd,
  input  logic       refused,
  output logic       err_flag
);
  logic do_clear;
  assign do_clear = (cmd == CMD_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else        err_flag <= refused || (err_flag && !do_clear);
  end

  a_r6_refusal_sets: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> err_flag);
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !do_clear) |=> err_flag);
endmodule

// File: rtl/ovl_read_mux.sv
module ovl_read_mux
  import ovl_pkg::*;
#(
  parameter int         ADDR_W   = 18,
  parameter int         DATA_W   = 32,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hF0,
  parameter logic [2:0] VER_CODE = 3'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data
);
  logic       low_loc;
  logic [7:0] code;
  assign low_loc = (addr[ADDR_W-1:2] == '0);
  assign code    = low_loc ? ident_code(addr[1:0], MFR_CODE, DEV_CODE, VER_CODE) : 8'd0;

  always_comb begin
    rd_data = array_rdata;
    if (sig_mode) rd_data = {{(DATA_W-8){1'b0}}, code};
  end

  a_r7_mfr_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_mode && addr == '0) |-> (rd_data[7:0] == MFR_CODE));
  a_r8_array_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_mode |-> (rd_data == array_rdata));
endmodule

// File: rtl/ovl_access_ctrl.sv
module ovl_access_ctrl
  import ovl_pkg::*;
#(
  parameter int         ADDR_W   = 18,
  parameter int         DATA_W   = 32,
  parameter int         NUM_BLK  = 32,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hF0,
  parameter logic [2:0] VER_CODE = 3'd0,
  localparam int        BLK_W    = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_ok,
  input  logic [2:0]        cmd,
  input  logic [1:0]        acc_op,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [BLK_W-1:0]  blk_idx,
  output logic              sel_overlay,
  output logic              grant,
  output logic              refused,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_flag,
  output logic              ovl_en,
  output logic              sig_mode
);
  assign blk_idx = acc_addr[ADDR_W-1 -: BLK_W];

  ovl_mode_regs u_modes (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .ovl_en(ovl_en), .sig_mode(sig_mode)
  );

  ovl_gate #(.BLK_W(BLK_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .acc_op(acc_op), .blk(blk_idx), .vpp_ok(vpp_ok),
    .ovl_en(ovl_en), .sig_mode(sig_mode), .sel_overlay(sel_overlay),
    .grant(grant), .refused(refused)
  );

  ovl_err_track u_err (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .refused(refused), .err_flag(err_flag)
  );

  ovl_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE),
    .DEV_CODE(DEV_CODE), .VER_CODE(VER_CODE)
  ) u_rmux (
    .clk(clk), .rst_n(rst_n), .sig_mode(sig_mode), .addr(acc_addr),
    .array_rdata(array_rdata), .rd_data(rd_data)
  );

  a_r1_blk_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr < ADDR_W'(1 << (ADDR_W - BLK_W))) |-> (blk_idx == '0));
endmodule

// File: tb/ovl_access_ctrl_bench.sv
module ovl_access_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vpp_ok = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  acc_op = 2'd0;
  logic [17:0] acc_addr = '0;
  logic [31:0] array_rdata = 32'hA5A5_0001;
  logic [4:0]  blk_idx;
  logic        sel_overlay, grant, refused, err_flag, ovl_en, sig_mode;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  logic m_ovl = 1'b0;

  always #2 clk = ~clk;

  ovl_access_ctrl #(.VER_CODE(3'd6)) u_ovl_access_ctrl (
    .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .cmd(cmd), .acc_op(acc_op),
    .acc_addr(acc_addr), .array_rdata(array_rdata), .blk_idx(blk_idx),
    .sel_overlay(sel_overlay), .grant(grant), .refused(refused), .rd_data(rd_data),
    .err_flag(err_flag), .ovl_en(ovl_en), .sig_mode(sig_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c);
    @(negedge clk); cmd = c;
    @(posedge clk);
    @(negedge clk); cmd = 3'd0;
  endtask

  // {cmd, vpp, op, addr, exp_sel, exp_grant}
  localparam logic [25:0] VEC [8] = '{
    {3'd0, 1'b1, 2'd1, 18'h00010, 1'b0, 1'b1},
    {3'd3, 1'b1, 2'd1, 18'h01FFF, 1'b1, 1'b1},
    {3'd0, 1'b0, 2'd1, 18'h00005, 1'b0, 1'b1},
    {3'd0, 1'b1, 2'd1, 18'h02000, 1'b0, 1'b1},
    {3'd0, 1'b1, 2'd2, 18'h00000, 1'b0, 1'b1},
    {3'd0, 1'b1, 2'd3, 18'h3E000, 1'b0, 1'b1},
    {3'd3, 1'b1, 2'd1, 18'h00100, 1'b0, 1'b1},
    {3'd0, 1'b0, 2'd3, 18'h24000, 1'b0, 1'b0}
  };

  initial begin
    #200000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R5 reset ovl_en", {31'd0, ovl_en}, 32'd0);
    chk("R8 reset sig_mode", {31'd0, sig_mode}, 32'd0);
    chk("R6 reset err_flag", {31'd0, err_flag}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      logic [2:0]  vc;
      logic        vv;
      logic [1:0]  vo;
      logic [17:0] va;
      {vc, vv, vo, va} = VEC[i][25:2];
      send(vc);
      if (vc == 3'd3) m_ovl = ~m_ovl;
      vpp_ok = vv; acc_op = vo; acc_addr = va;
      #1;
      chk("R5 ovl_en flag", {31'd0, ovl_en}, {31'd0, m_ovl});
      chk("R1 block index", {27'd0, blk_idx}, {27'd0, 5'(va >> 13)});
      chk("R2 overlay select", {31'd0, sel_overlay}, {31'd0, VEC[i][1]});
      chk("R3 R4 grant", {31'd0, grant}, {31'd0, VEC[i][0]});
      chk("R3 R4 refused", {31'd0, refused},
          {31'd0, (vo >= 2'd2) && !vv});
    end

    // R6: refusal in last vector captured at the following edge
    @(negedge clk); acc_op = 2'd0;
    #1 chk("R6 set after refusal", {31'd0, err_flag}, 32'd1);
    vpp_ok = 1'b1; acc_op = 2'd2;
    @(negedge clk); acc_op = 2'd0;
    #1 chk("R6 stays set", {31'd0, err_flag}, 32'd1);
    send(3'd4);
    #1 chk("R6 cleared", {31'd0, err_flag}, 32'd0);
    // R6: refusal and clear together -> set
    vpp_ok = 1'b0; acc_op = 2'd3; cmd = 3'd4;
    @(negedge clk); cmd = 3'd0; acc_op = 2'd0; vpp_ok = 1'b1;
    #1 chk("R6 set wins over clear", {31'd0, err_flag}, 32'd1);
    send(3'd0);
    #1 chk("R8 none keeps state", {31'd0, err_flag}, 32'd1);

    // R7 identification mode, overlay enabled
    send(3'd3);
    send(3'd2);
    acc_op = 2'd1;
    acc_addr = 18'd0; #1 chk("R7 mfr code", rd_data, 32'h20);
    chk("R2 no overlay in ident mode", {31'd0, sel_overlay}, 32'd0);
    acc_addr = 18'd1; #1 chk("R7 dev code", rd_data, 32'hF0);
    acc_addr = 18'd2; #1 chk("R7 version", rd_data, 32'd6);
    acc_addr = 18'd3; #1 chk("R7 unused loc", rd_data, 32'd0);
    acc_addr = 18'h00004; #1 chk("R7 addr 4 zero", rd_data, 32'd0);
    send(3'd1);
    acc_addr = 18'd0; array_rdata = 32'hDEAD_BEEF;
    #1 chk("R8 array data", rd_data, 32'hDEAD_BEEF);
    chk("R2 overlay back in array", {31'd0, sel_overlay}, 32'd1);

    // R5/R8 reset clears everything
    send(3'd2);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R5 reset clears ovl_en", {31'd0, ovl_en}, 32'd0);
    chk("R8 reset array mode", {31'd0, sig_mode}, 32'd0);
    chk("R6 reset clears err", {31'd0, err_flag}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule